// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that retires one instruction in every clock cycle. On each cycle it reads the instruction that the program counter addresses from an internal instruction array. It decodes the instruction and reads up to two source registers. The ALU then adds, subtracts or ORs the operands. A result goes to the register file or to an internal data array, and the next program counter is chosen. The supported operations are register add and subtract, OR with a zero-extended immediate, word load, word store, branch on equal and an absolute jump inside the current 256 MB region.

Both memories are word arrays inside the core. A loader port writes them, usually while reset is held. A combinational peek port reads either array back. The load port has no ready signal: a word offered with `load_en` high is written at the next rising edge. Because nothing can stall it, the source never has to wait. A debug port shows the current program counter. It also shows the register-file write that the instruction now executing will perform at the next edge.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high the program counter is 0 at every rising edge, `dbg_we` is low, and the core writes neither registers nor data memory.
- R2: Opcode 000000 with bits [10:0] equal to 00000_100000 writes rs + rt into rd. With bits [10:0] equal to 00000_100010 it writes rs − rt into rd. Both wrap modulo 2^32. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11].
- R3: Opcode 001101 writes rs OR {16'h0, imm[15:0]} into rt.
- R4: Opcode 100011 loads into rt the data word at byte address rs + sign-extended imm. The array is indexed by address bits [DMEM_AW+1:2], and the low two bits are ignored.
- R5: Opcode 101011 stores rt at the same computed address. No other instruction writes data memory.
- R6: Opcode 000100 sets the next PC to PC+4 + (sign-extended imm << 2) when rs equals rt. Otherwise the next PC is PC+4.
- R7: Opcode 000010 sets the next PC to {PC+4 [31:28], instr[25:0], 2'b00}.
- R8: Every other instruction advances the PC by 4 at each rising edge.
- R9: Register 0 reads as zero, and writes to it are discarded.
- R10: An instruction that reads and writes the same register sees the value held before that cycle.
- R11: Any opcode or R-type function code not listed above writes neither registers nor memory, and the PC advances by 4.
- R12: A `load_en` word goes into instruction memory when `load_imem` is 1 and into data memory when it is 0. The write takes priority over a store to the same cycle. `peek_data` shows the selected word combinationally.
- R13: `dbg_we`, `dbg_idx` and `dbg_data` show, during the executing cycle, the register write that completes at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write a word into a memory array |
| load_imem | input | 1 | 1 selects instruction memory, 0 data memory |
| load_addr | input | LD_AW | Word index for the loader |
| load_data | input | 32 | Word to write |
| peek_imem | input | 1 | 1 reads instruction memory, 0 data memory |
| peek_addr | input | LD_AW | Word index for read-back |
| peek_data | output | 32 | Word read back, combinational |
| pc | output | 32 | Current program counter |
| dbg_we | output | 1 | Register write happening this cycle |
| dbg_idx | output | RIW | Destination register of that write |
| dbg_data | output | 32 | Value being written |

## Verification
The debug write port and `peek_data` are combinational, so a result there is due in the same cycle as its cause. The PC, register and memory contents change at the next rising edge. The bench drives and samples 1 ns after each falling edge. At that point it compares the debug port with a model of the instruction that is executing, and the PC with the model's address for that cycle. It then steps the model once, so every PC check lands exactly one edge after the instruction that chose it. Memory contents are read back after the program has settled in its final self-loop.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_ORI   = 6'b001101;
  localparam logic [5:0] OPC_LW    = 6'b100011;
  localparam logic [5:0] OPC_SW    = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_J     = 6'b000010;

  localparam logic [5:0] FN_ADDU = 6'b100000;
  localparam logic [5:0] FN_SUBU = 6'b100010;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_SUB  = 2'd1,
    ALU_OR   = 2'd2,
    ALU_NONE = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;    // destination from rd instead of rt
    logic    src_imm;   // ALU B operand from extended immediate
    logic    wb_mem;    // write back the loaded word
    logic    reg_we;
    logic    mem_we;
    logic    br_eq;
    logic    jump;
    logic    ext_sign;  // 1: sign extend, 0: zero extend
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_core_ctrl.sv
module sc_core_ctrl
  import sc_core_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [10:0] rtype_lo,
  output ctrl_t       ctrl
);

  logic [4:0] shamt;
  logic [5:0] funct;
  assign shamt = rtype_lo[10:6];
  assign funct = rtype_lo[5:0];

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_NONE;
    case (opcode)
      OPC_RTYPE: begin
        if (shamt == 5'd0 && (funct == FN_ADDU || funct == FN_SUBU)) begin
          ctrl.dst_rd = 1'b1;
          ctrl.reg_we = 1'b1;
          ctrl.alu_op = (funct == FN_SUBU) ? ALU_SUB : ALU_ADD;
        end
      end
      OPC_ORI: begin
        ctrl.src_imm = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.alu_op  = ALU_OR;
      end
      OPC_LW: begin
        ctrl.src_imm  = 1'b1;
        ctrl.wb_mem   = 1'b1;
        ctrl.reg_we   = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.alu_op   = ALU_ADD;
      end
      OPC_SW: begin
        ctrl.src_imm  = 1'b1;
        ctrl.mem_we   = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.alu_op   = ALU_ADD;
      end
      OPC_BEQ: begin
        ctrl.br_eq  = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OPC_J: ctrl.jump = 1'b1;
      default: ;
    endcase
  end

  // R11
  always_comb begin
    kind_onehot_chk: assert ($onehot0({ctrl.reg_we, ctrl.mem_we, ctrl.br_eq, ctrl.jump}));
  end

  // R5
  always_comb begin
    if (ctrl.mem_we) begin
      store_addr_mode_chk: assert (ctrl.src_imm && ctrl.ext_sign && ctrl.alu_op == ALU_ADD);
    end
  end

endmodule

// File: rtl/sc_core_alu.sv
module sc_core_alu
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

  // R6
  always_comb begin
    if (op == ALU_SUB) begin
      eq_from_sub_chk: assert (zero == (a == b));
    end
  end

endmodule

// File: rtl/sc_core_regfile.sv
module sc_core_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] ra_idx,
  output logic [W-1:0]  ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [W-1:0]  rb_data,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && widx != '0) regs[widx] <= wdata;
  end

  assign ra_data = (ra_idx == '0) ? '0 : regs[ra_idx];
  assign rb_data = (rb_idx == '0) ? '0 : regs[rb_idx];

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_idx == '0) |-> (ra_data == '0));

  // R10
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (we && widx != '0) |=> (regs[$past(widx)] == $past(wdata)));

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int NREG    = 32,
  parameter int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW,
  parameter int RIW     = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             load_imem,
  input  logic [LD_AW-1:0] load_addr,
  input  logic [31:0]      load_data,
  input  logic             peek_imem,
  input  logic [LD_AW-1:0] peek_addr,
  output logic [31:0]      peek_data,
  output logic [31:0]      pc,
  output logic             dbg_we,
  output logic [RIW-1:0]   dbg_idx,
  output logic [31:0]      dbg_data
);

  localparam int IDEPTH = 2 ** IMEM_AW;
  localparam int DDEPTH = 2 ** DMEM_AW;

  logic [XLEN-1:0] imem [IDEPTH];
  logic [XLEN-1:0] dmem [DDEPTH];

  logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_target, jmp_target, instr;
  logic [5:0]      opcode;
  logic [15:0]     imm;
  logic [XLEN-1:0] imm_ext, br_off, rs_data, rt_data, alu_b, alu_y, wb_data, ld_word;
  logic [RIW-1:0]  dest;
  logic            alu_zero, taken, reg_we, mem_we;
  ctrl_t           ctrl;

  assign instr  = imem[pc_q[IMEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign imm    = instr[15:0];

  sc_core_ctrl u_ctrl (
    .opcode   (opcode),
    .rtype_lo (instr[10:0]),
    .ctrl     (ctrl)
  );

  sc_core_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .ra_idx  (instr[21+RIW-1:21]),
    .ra_data (rs_data),
    .rb_idx  (instr[16+RIW-1:16]),
    .rb_data (rt_data),
    .we      (reg_we),
    .widx    (dest),
    .wdata   (wb_data)
  );

  assign imm_ext = ctrl.ext_sign ? {{16{imm[15]}}, imm} : {16'h0000, imm};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_data;

  sc_core_alu #(.W(XLEN)) u_alu (
    .a    (rs_data),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign ld_word = dmem[alu_y[DMEM_AW+1:2]];
  assign wb_data = ctrl.wb_mem ? ld_word : alu_y;
  assign dest    = ctrl.dst_rd ? instr[11+RIW-1:11] : instr[16+RIW-1:16];
  assign reg_we  = ctrl.reg_we & ~rst;
  assign mem_we  = ctrl.mem_we & ~rst;

  // next-address paths: sequential, PC-relative, pseudo-direct
  assign pc_plus4   = pc_q + 32'd4;
  assign br_off     = {{14{imm[15]}}, imm, 2'b00};
  assign br_target  = pc_plus4 + br_off;
  assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign taken      = ctrl.br_eq & alu_zero;

  always_comb begin
    if (ctrl.jump)  pc_next = jmp_target;
    else if (taken) pc_next = br_target;
    else            pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (load_en && load_imem) imem[load_addr[IMEM_AW-1:0]] <= load_data;
  end

  always_ff @(posedge clk) begin
    if (load_en && !load_imem)  dmem[load_addr[DMEM_AW-1:0]] <= load_data;
    else if (mem_we)            dmem[alu_y[DMEM_AW+1:2]] <= rt_data;
  end

  assign peek_data = peek_imem ? imem[peek_addr[IMEM_AW-1:0]] : dmem[peek_addr[DMEM_AW-1:0]];
  assign pc        = pc_q;
  assign dbg_we    = reg_we;
  assign dbg_idx   = dest;
  assign dbg_data  = wb_data;

  // R1
  pc_reset_chk: assert property (@(posedge clk) $past(rst) |-> (pc_q == '0));

  // R8
  pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !taken) |=> (pc_q == $past(pc_q) + 32'd4));

  // R7
  jump_region_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pc_q[31:28] == $past(pc_plus4[31:28]) && pc_q[1:0] == 2'b00));

  // R5
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (opcode == OPC_SW));

  // R1
  pc_align_chk: assert property (@(posedge clk) disable iff (rst) pc_q[1:0] == 2'b00);

endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;

  localparam int AW   = 6;
  localparam int NPRG = 22;

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'b00000, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] im);
    return {op, rs[4:0], rt[4:0], im};
  endfunction
  function automatic logic [31:0] enc_j(input logic [25:0] tg);
    return {6'b000010, tg};
  endfunction

  // program table: each entry is the stimulus word at that word address
  localparam logic [31:0] PROG [NPRG] = '{
    enc_i(6'b001101, 0, 1, 16'h0005),   // 0  ori r1 = 5
    enc_i(6'b001101, 0, 2, 16'hFFFF),   // 1  ori r2 = 0000FFFF
    enc_r(1, 2, 3, 6'b100000),          // 2  addu r3
    enc_r(1, 2, 4, 6'b100010),          // 3  subu r4 (wraps)
    enc_i(6'b101011, 0, 3, 16'h0008),   // 4  sw r3 -> word 2
    enc_i(6'b100011, 0, 5, 16'h0008),   // 5  lw r5
    enc_i(6'b001101, 0, 6, 16'h0010),   // 6  ori r6 = 16
    enc_i(6'b100011, 6, 7, 16'hFFF8),   // 7  lw r7, negative offset
    enc_r(1, 1, 0, 6'b100000),          // 8  write to r0
    enc_r(0, 0, 8, 6'b100000),          // 9  r8 = r0 + r0
    enc_i(6'b000100, 5, 7, 16'h0003),   // 10 beq taken -> 14
    enc_i(6'b001101, 0, 9, 16'h0BAD),   // 11 skipped
    enc_i(6'b001101, 0, 9, 16'h0BAD),   // 12 skipped
    enc_i(6'b001101, 0, 9, 16'h0BAD),   // 13 skipped
    enc_i(6'b000100, 1, 2, 16'h0005),   // 14 beq not taken
    32'hFC00_0000,                      // 15 unknown opcode
    enc_r(1, 2, 9, 6'b100001),          // 16 unknown funct
    enc_r(1, 1, 1, 6'b100000),          // 17 r1 = r1 + r1
    enc_j(26'd20),                      // 18 jump -> 20
    enc_i(6'b001101, 0, 9, 16'h0BAD),   // 19 skipped
    enc_i(6'b101011, 6, 4, 16'h0004),   // 20 sw r4 -> word 5
    enc_i(6'b000100, 0, 0, 16'hFFFF)    // 21 self loop
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             load_en, load_imem, peek_imem;
  logic [AW-1:0]    load_addr, peek_addr;
  logic [31:0]      load_data, peek_data, pc, dbg_data;
  logic             dbg_we;
  logic [4:0]       dbg_idx;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [31:0] m_rf [32];
  logic [31:0] m_dm [64];
  logic [31:0] m_im [64];
  logic [31:0] m_pc;

  always #5 clk = ~clk;

  sc_core u_sc_core (
    .clk(clk), .rst(rst), .load_en(load_en), .load_imem(load_imem),
    .load_addr(load_addr), .load_data(load_data), .peek_imem(peek_imem),
    .peek_addr(peek_addr), .peek_data(peek_data), .pc(pc),
    .dbg_we(dbg_we), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int idx);
    case (idx)
      0, 1, 6: return "R3";
      2, 3:    return "R2";
      4, 20:   return "R5";
      5, 7:    return "R4";
      8, 9:    return "R9";
      10, 14, 21: return "R6";
      15, 16:  return "R11";
      17:      return "R10";
      18:      return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired: actual=%0d expected=%0d", cycles, 5000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; load_en = 1'b0; load_imem = 1'b0; load_addr = '0; load_data = '0;
    peek_imem = 1'b0; peek_addr = '0;
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    for (int i = 0; i < 64; i++) begin
      m_im[i] = (i < NPRG) ? PROG[i] : 32'h0000_0000;
      m_dm[i] = 32'hA500_0000 | i;
    end
    repeat (2) @(negedge clk);

    // preload both arrays through the loader (R12)
    for (int i = 0; i < 64; i++) begin
      load_en = 1'b1; load_imem = 1'b1; load_addr = i[AW-1:0]; load_data = m_im[i];
      @(negedge clk);
    end
    for (int i = 0; i < 64; i++) begin
      load_en = 1'b1; load_imem = 1'b0; load_addr = i[AW-1:0]; load_data = m_dm[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    #1;
    // R1 reset state
    check(pc == 32'd0, "R1", "pc in reset", pc, 32'd0);
    check(dbg_we == 1'b0, "R1", "no reg write in reset", {31'd0, dbg_we}, 32'd0);
    // R12 read-back
    peek_imem = 1'b1; peek_addr = 6'd3; #1;
    check(peek_data == PROG[3], "R12", "imem read-back", peek_data, PROG[3]);
    peek_imem = 1'b0; peek_addr = 6'd7; #1;
    check(peek_data == m_dm[7], "R12", "dmem read-back", peek_data, m_dm[7]);

    // run the program against the model
    @(negedge clk);
    rst = 1'b0;
    m_pc = 32'd0;
    for (int s = 0; s < 30; s++) begin
      logic [31:0] ins, a, b, ext, res, nx;
      logic [5:0]  op;
      logic        we;
      int          wi, idx;
      string       tg;
      #1;
      idx = int'(m_pc[7:2]);
      tg  = tag_of(idx);
      check(pc == m_pc, tg, "pc", pc, m_pc);
      ins = m_im[idx];
      op  = ins[31:26];
      a   = m_rf[ins[25:21]];
      b   = m_rf[ins[20:16]];
      ext = {{16{ins[15]}}, ins[15:0]};
      we = 1'b0; wi = 0; res = '0;
      nx = m_pc + 32'd4;
      case (op)
        6'b000000: if (ins[10:0] == 11'h020) begin we = 1; wi = ins[15:11]; res = a + b; end
                   else if (ins[10:0] == 11'h022) begin we = 1; wi = ins[15:11]; res = a - b; end
        6'b001101: begin we = 1; wi = ins[20:16]; res = a | {16'h0, ins[15:0]}; end
        6'b100011: begin we = 1; wi = ins[20:16]; res = m_dm[(a + ext) >> 2 & 32'h3F]; end
        6'b101011: m_dm[(a + ext) >> 2 & 32'h3F] = b;
        6'b000100: if (a == b) nx = m_pc + 32'd4 + (ext << 2);
        6'b000010: nx = {nx[31:28], ins[25:0], 2'b00};
        default: ;
      endcase
      check(dbg_we == we, (idx == 8 || idx == 9) ? "R13" : tg, "write strobe", {31'd0, dbg_we}, {31'd0, we});
      if (we) begin
        check(dbg_idx == wi[4:0], tg, "write index", {27'd0, dbg_idx}, wi);
        check(dbg_data == res, tg, "write data", dbg_data, res);
        if (wi != 0) m_rf[wi] = res;
      end
      m_pc = nx;
      @(negedge clk);
    end

    // R9 / R10 / R3 spot values held by the model
    check(m_rf[8] == 32'd0, "R9", "r0 reads zero after write", m_rf[8], 32'd0);
    check(m_rf[1] == 32'd10, "R10", "old value used", m_rf[1], 32'd10);
    check(m_rf[9] == 32'd0, "R6", "skipped code never wrote", m_rf[9], 32'd0);

    // final data memory, all words
    for (int i = 0; i < 64; i++) begin
      peek_imem = 1'b0; peek_addr = i[AW-1:0]; #1;
      check(peek_data == m_dm[i], (i == 2 || i == 5) ? "R5" : "R11", "dmem final", peek_data, m_dm[i]);
    end

    // mid-run reset
    rst = 1'b1;
    @(negedge clk); #1;
    check(pc == 32'd0, "R1", "pc after mid-run reset", pc, 32'd0);
    check(dbg_we == 1'b0, "R1", "no write in reset", {31'd0, dbg_we}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule